// File: doc/BRIEF.md
# Multi-Cycle RISC Datapath Core

This block is the data side of a 32-bit processor that completes each instruction over several short clock cycles. It supports a small instruction subset: word load, word store, branch-if-equal, unconditional jump, and register-to-register arithmetic and logic. A single memory port serves both instruction fetch and data access. A single ALU handles all arithmetic: it advances the program counter, computes branch targets and effective addresses, and executes register operations. Holding registers carry values from one cycle to the next: an instruction register, a memory data register, two operand latches and an ALU result latch.

An external sequencer drives the block. Every cycle it supplies the multiplexer selects and write strobes. In return it reads the opcode field of the held instruction and the zero flag of the ALU. Internally, a small control module turns the raw strobes into a packed strobe struct for the datapath. It also decodes the ALU function and forms the qualified program-counter load. Memory sits outside the block, behind an address, write-data, read-data and read/write strobe interface. Read data is expected combinationally for the presented address.

Instruction fields, bit 31 down:
- opcode [31:26]
- source register rs [25:21]
- second register rt [20:16]
- destination rd [15:11]
- function code [5:0]
- 16-bit immediate [15:0]
- 26-bit jump index [25:0]

Top module: `mc_core`

## Requirements
- R1: `memAddr` presents the program counter when `iorD`=0, and the ALU result latch when `iorD`=1.
- R2: With `aluSrcA`=0, `aluSrcB`=01, `aluOp`=00, `pcSrc`=00 and `pcWrite`=1, the program counter advances by 4. The instruction register loads `memRdata` only in cycles where `irWrite`=1 and otherwise holds its value.
- R3: `aluSrcB`=10 selects the sign-extended immediate, so a negative offset subtracts from the base register. `aluSrcB`=11 selects the sign-extended immediate shifted left by two, which forms branch targets. `aluSrcB`=00 selects latch B.
- R4: The ALU operation is chosen as follows:
  - `aluOp`=00 adds and `aluOp`=01 subtracts.
  - `aluOp`=10 decodes the function code: 0x20 add, 0x22 subtract, 0x24 bitwise and, 0x25 bitwise or, 0x2A signed set-less-than (result 1 or 0).
  - Any other combination adds.
- R5: With `pcWriteCond`=1 and `pcSrc`=01, the program counter takes the ALU result latch when the current ALU result is zero. Otherwise it holds.
- R6: With `pcWrite`=1 and `pcSrc`=10, the program counter becomes its own upper four bits, then the instruction's 26-bit jump index, then two zero bits.
- R7: A register-file write (`regWrite`=1) targets:
  - rd when `regDst`=1, and rt when `regDst`=0;
  - with data from the ALU result latch when `memToReg`=0, and from the memory data register when `memToReg`=1.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: After active-low reset the program counter is 0 and the instruction register is 0, so `memAddr`=0 and `opcode`=0 with `iorD`=0.
- R10: `memWdata` presents operand latch B. `memWe` follows `memWrite` and `memRe` follows `memRead`.
- R11: `opcode` shows bits [31:26] of the instruction register. `zero` is 1 exactly when the current ALU result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pcWrite | input | 1 | Unconditional program counter load |
| pcWriteCond | input | 1 | Program counter load qualified by zero |
| iorD | input | 1 | Memory address select: 0 PC, 1 ALU latch |
| memRead | input | 1 | Memory read strobe |
| memWrite | input | 1 | Memory write strobe |
| irWrite | input | 1 | Instruction register load |
| memToReg | input | 1 | Register write data select |
| pcSrc | input | 2 | Next PC select |
| aluOp | input | 2 | ALU operation class |
| aluSrcA | input | 1 | ALU first operand select |
| aluSrcB | input | 2 | ALU second operand select |
| regWrite | input | 1 | Register file write enable |
| regDst | input | 1 | Register write address select |
| memAddr | output | 32 | Memory address |
| memWdata | output | 32 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRe | output | 1 | Memory read enable |
| memRdata | input | 32 | Memory read data |
| opcode | output | 6 | Opcode field of held instruction |
| zero | output | 1 | ALU result is zero |

## Verification
The bench builds the core with its default 32-bit data width and 32 registers. This makes the real field layout available, so the sign extension of 0xFFFC and the jump-index placement are exercised at full width. The bench acts as the sequencer, stepping fetch, decode, execute, memory and write-back strobes one cycle at a time against a 256-word array. The whole register file and the upper program-counter bits stay in reach, but the program stays below 0x400, so the upper four PC bits are always zero in the jump check.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN    = 32;
  localparam int NREG    = 32;
  localparam int REG_AW  = $clog2(NREG);

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } aluFn_e;

  typedef struct packed {
    logic       iorD;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [1:0] pcSrc;
    logic       irWrite;
    logic       regWrite;
    logic       regDst;
    logic       memToReg;
    aluFn_e     aluFn;
  } dpStrobe_t;
endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       iorD,
  input  logic       aluSrcA,
  input  logic [1:0] aluSrcB,
  input  logic [1:0] pcSrc,
  input  logic       irWrite,
  input  logic       regWrite,
  input  logic       regDst,
  input  logic       memToReg,
  input  logic [1:0] aluOp,
  input  logic [5:0] funct,
  input  logic       pcWrite,
  input  logic       pcWriteCond,
  input  logic       zero,
  output dpStrobe_t  strobe,
  output logic       pcLoad
);
  aluFn_e fnSel;

  always_comb begin
    unique case (aluOp)
      2'b00: fnSel = ALU_ADD;
      2'b01: fnSel = ALU_SUB;
      2'b10: begin
        unique case (funct)
          FN_SUB:  fnSel = ALU_SUB;
          FN_AND:  fnSel = ALU_AND;
          FN_OR:   fnSel = ALU_OR;
          FN_SLT:  fnSel = ALU_SLT;
          default: fnSel = ALU_ADD;
        endcase
      end
      default: fnSel = ALU_ADD;
    endcase
  end

  always_comb begin
    strobe.iorD     = iorD;
    strobe.aluSrcA  = aluSrcA;
    strobe.aluSrcB  = aluSrcB;
    strobe.pcSrc    = pcSrc;
    strobe.irWrite  = irWrite;
    strobe.regWrite = regWrite;
    strobe.regDst   = regDst;
    strobe.memToReg = memToReg;
    strobe.aluFn    = fnSel;
  end

  assign pcLoad = pcWrite | (pcWriteCond & zero);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int NR = NREG,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);
  logic [W-1:0] cells [NR];

  assign cells[0] = '0;

  for (genvar i = 1; i < NR; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wrEn && (wrAddr == AW'(i))) cells[i] <= wrData;
    end
  end

  assign rdDataA = cells[rdAddrA];
  assign rdDataB = cells[rdAddrB];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobe_t    strobe,
  input  logic         pcLoad,
  input  logic [W-1:0] memRdata,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  output logic [W-1:0] pcQ,
  output logic [W-1:0] irQ,
  output logic [W-1:0] aluOutQ,
  output logic         zero
);
  logic [W-1:0] mdrQ, aQ, bQ;
  logic [W-1:0] rfA, rfB, opA, opB, aluRes, immExt, pcNext, wrData;
  logic [REG_AW-1:0] wrAddr;

  assign immExt = {{(W-16){irQ[15]}}, irQ[15:0]};
  assign opA    = strobe.aluSrcA ? aQ : pcQ;

  always_comb begin
    unique case (strobe.aluSrcB)
      2'b00:   opB = bQ;
      2'b01:   opB = W'(4);
      2'b10:   opB = immExt;
      default: opB = immExt << 2;
    endcase
  end

  always_comb begin
    unique case (strobe.aluFn)
      ALU_SUB: aluRes = opA - opB;
      ALU_AND: aluRes = opA & opB;
      ALU_OR:  aluRes = opA | opB;
      ALU_SLT: aluRes = ($signed(opA) < $signed(opB)) ? W'(1) : '0;
      default: aluRes = opA + opB;
    endcase
  end

  assign zero = (aluRes == '0);

  always_comb begin
    unique case (strobe.pcSrc)
      2'b00:   pcNext = aluRes;
      2'b01:   pcNext = aluOutQ;
      default: pcNext = {pcQ[W-1:W-4], irQ[25:0], 2'b00};
    endcase
  end

  assign wrAddr   = strobe.regDst ? irQ[15:11] : irQ[20:16];
  assign wrData   = strobe.memToReg ? mdrQ : aluOutQ;
  assign memAddr  = strobe.iorD ? aluOutQ : pcQ;
  assign memWdata = bQ;

  mc_regfile #(.W(W), .NR(NREG)) u_rf (
    .clk     (clk),
    .rdAddrA (irQ[25:21]),
    .rdAddrB (irQ[20:16]),
    .rdDataA (rfA),
    .rdDataB (rfB),
    .wrEn    (strobe.regWrite),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ     <= '0;
      irQ     <= '0;
      mdrQ    <= '0;
      aQ      <= '0;
      bQ      <= '0;
      aluOutQ <= '0;
    end else begin
      if (pcLoad)         pcQ <= pcNext;
      if (strobe.irWrite) irQ <= memRdata;
      mdrQ    <= memRdata;
      aQ      <= rfA;
      bQ      <= rfB;
      aluOutQ <= aluRes;
    end
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pcWrite,
  input  logic        pcWriteCond,
  input  logic        iorD,
  input  logic        memRead,
  input  logic        memWrite,
  input  logic        irWrite,
  input  logic        memToReg,
  input  logic [1:0]  pcSrc,
  input  logic [1:0]  aluOp,
  input  logic        aluSrcA,
  input  logic [1:0]  aluSrcB,
  input  logic        regWrite,
  input  logic        regDst,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic        memWe,
  output logic        memRe,
  input  logic [31:0] memRdata,
  output logic [5:0]  opcode,
  output logic        zero
);
  dpStrobe_t strobe;
  logic pcLoad;
  logic [XLEN-1:0] pcQ, irQ, aluOutQ;

  mc_ctrl u_ctrl (
    .iorD (iorD), .aluSrcA (aluSrcA), .aluSrcB (aluSrcB), .pcSrc (pcSrc),
    .irWrite (irWrite), .regWrite (regWrite), .regDst (regDst),
    .memToReg (memToReg), .aluOp (aluOp), .funct (irQ[5:0]),
    .pcWrite (pcWrite), .pcWriteCond (pcWriteCond), .zero (zero),
    .strobe (strobe), .pcLoad (pcLoad)
  );

  mc_datapath #(.W(XLEN)) u_dp (
    .clk (clk), .rstN (rstN), .strobe (strobe), .pcLoad (pcLoad),
    .memRdata (memRdata), .memAddr (memAddr), .memWdata (memWdata),
    .pcQ (pcQ), .irQ (irQ), .aluOutQ (aluOutQ), .zero (zero)
  );

  assign memWe  = memWrite;
  assign memRe  = memRead;
  assign opcode = irQ[31:26];
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
  input logic        clk,
  input logic        rstN,
  input logic        pcWrite,
  input logic        pcWriteCond,
  input logic        iorD,
  input logic        irWrite,
  input logic        aluSrcA,
  input logic [1:0]  aluSrcB,
  input logic [1:0]  aluOp,
  input logic [1:0]  pcSrc,
  input logic        zero,
  input logic [31:0] memAddr,
  input logic [31:0] pcQ,
  input logic [31:0] irQ,
  input logic [31:0] aluOutQ
);
  AST_ADDR_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    memAddr == (iorD ? aluOutQ : pcQ)); // R1

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !irWrite |=> $stable(irQ)); // R2

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrite && pcSrc == 2'b00 && !aluSrcA && aluSrcB == 2'b01 && aluOp == 2'b00)
    |=> pcQ == $past(pcQ) + 32'd4); // R2

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!pcWrite && !(pcWriteCond && zero)) |=> $stable(pcQ)); // R5

  AST_BRANCH_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (!pcWrite && pcWriteCond && zero && pcSrc == 2'b01) |=> pcQ == $past(aluOutQ)); // R5

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrite && pcSrc == 2'b10)
    |=> pcQ == {$past(pcQ[31:28]), $past(irQ[25:0]), 2'b00}); // R6
endmodule

bind mc_core mc_core_chk u_chk (
  .clk (clk), .rstN (rstN), .pcWrite (pcWrite), .pcWriteCond (pcWriteCond),
  .iorD (iorD), .irWrite (irWrite), .aluSrcA (aluSrcA), .aluSrcB (aluSrcB),
  .aluOp (aluOp), .pcSrc (pcSrc), .zero (zero), .memAddr (memAddr),
  .pcQ (pcQ), .irQ (irQ), .aluOutQ (aluOutQ)
);

// File: tb/mc_core_tb.sv
module mc_core_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [69:0] VEC [7] = '{
    {6'h20, 32'd5,        32'd7},
    {6'h22, 32'd3,        32'd10},
    {6'h24, 32'hF0F0_1234, 32'h0FF0_FF00},
    {6'h25, 32'hA000_0001, 32'h0500_0010},
    {6'h2A, 32'hFFFF_FFFF, 32'd1},
    {6'h2A, 32'd5,        32'd2},
    {6'h22, 32'd77,       32'd77}
  };

  logic clk = 0, rstN = 0;
  logic pcWrite, pcWriteCond, iorD, memRead, memWrite, irWrite, memToReg;
  logic aluSrcA, regWrite, regDst;
  logic [1:0] pcSrc, aluOp, aluSrcB;
  logic [31:0] memAddr, memWdata, memRdata;
  logic memWe, memRe, zero;
  logic [5:0] opcode;

  logic [31:0] mem [256];
  logic [31:0] pcModel, lastWdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign memRdata = mem[memAddr[9:2]];

  mc_core u_dut (
    .clk (clk), .rstN (rstN), .pcWrite (pcWrite), .pcWriteCond (pcWriteCond),
    .iorD (iorD), .memRead (memRead), .memWrite (memWrite), .irWrite (irWrite),
    .memToReg (memToReg), .pcSrc (pcSrc), .aluOp (aluOp), .aluSrcA (aluSrcA),
    .aluSrcB (aluSrcB), .regWrite (regWrite), .regDst (regDst),
    .memAddr (memAddr), .memWdata (memWdata), .memWe (memWe), .memRe (memRe),
    .memRdata (memRdata), .opcode (opcode), .zero (zero)
  );

  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction
  function automatic logic [31:0] refAlu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clr;
    pcWrite = 0; pcWriteCond = 0; iorD = 0; memRead = 0; memWrite = 0;
    irWrite = 0; memToReg = 0; pcSrc = 0; aluOp = 0; aluSrcA = 0;
    aluSrcB = 0; regWrite = 0; regDst = 0;
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic fetchDecode(logic [31:0] instr);
    mem[pcModel[9:2]] = instr;
    clr; memRead = 1; irWrite = 1; aluSrcB = 2'b01; pcWrite = 1; tick;
    pcModel += 4;
    clr; aluSrcB = 2'b11; tick;
  endtask

  task automatic loadWord(logic [31:0] instr, logic [31:0] expAddr);
    fetchDecode(instr);
    clr; aluSrcA = 1; aluSrcB = 2'b10; tick;
    clr; iorD = 1; memRead = 1; #1;
    chk(memAddr == expAddr, "R1/R3 load address", memAddr, expAddr);
    tick;
    clr; regWrite = 1; memToReg = 1; tick;
  endtask

  task automatic storeWord(logic [31:0] instr);
    logic [31:0] a;
    fetchDecode(instr);
    clr; aluSrcA = 1; aluSrcB = 2'b10; tick;
    clr; iorD = 1; memWrite = 1; #1;
    chk(memWe == 1'b1, "R10 write strobe", 32'(memWe), 32'd1);
    a = memAddr; lastWdata = memWdata;
    tick;
    mem[a[9:2]] = lastWdata;
  endtask

  task automatic regOp(logic [31:0] instr);
    fetchDecode(instr);
    clr; aluSrcA = 1; aluOp = 2'b10; tick;
    clr; regWrite = 1; regDst = 1; tick;
  endtask

  task automatic branchEq(logic [31:0] instr, bit expZero);
    logic [31:0] base;
    base = pcModel;
    fetchDecode(instr);
    clr; aluSrcA = 1; aluOp = 2'b01; pcWriteCond = 1; pcSrc = 2'b01; #1;
    chk(zero == expZero, "R11 zero on compare", 32'(zero), 32'(expZero));
    tick;
    pcModel = expZero ? base + 4 + ({{16{instr[15]}}, instr[15:0]} << 2) : base + 4;
    clr; #1;
    chk(memAddr == pcModel, "R5 branch next PC", memAddr, pcModel);
  endtask

  initial begin
    clr;
    pcModel = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    #1;
    chk(memAddr == 0, "R9 reset PC", memAddr, 0);
    chk(opcode == 0, "R9 reset IR", 32'(opcode), 0);

    // R4 R7 table of ALU operations through load / op / store
    for (int i = 0; i < 7; i++) begin
      logic [5:0] fn;
      logic [31:0] a, b, e;
      {fn, a, b} = VEC[i];
      e = refAlu(fn, a, b);
      mem[224] = a; mem[225] = b;
      loadWord(encI(6'h23, 5'd0, 5'd1, 16'h0380), 32'h380);
      loadWord(encI(6'h23, 5'd0, 5'd2, 16'h0384), 32'h384);
      regOp(encR(5'd1, 5'd2, 5'd3, fn));
      storeWord(encI(6'h2B, 5'd0, 5'd3, 16'h0388));
      chk(lastWdata == e, "R4 ALU result", lastWdata, e);
      chk(mem[226] == e, "R7 rd write-back stored", mem[226], e);
    end

    // R8 register 0 ignores writes
    mem[224] = 32'h55;
    loadWord(encI(6'h23, 5'd0, 5'd1, 16'h0380), 32'h380);
    regOp(encR(5'd1, 5'd1, 5'd0, 6'h20));
    storeWord(encI(6'h2B, 5'd0, 5'd0, 16'h0388));
    chk(lastWdata == 0, "R8 r0 reads zero", lastWdata, 0);

    // R3 negative immediate, R7 load path via rt and MDR
    mem[227] = 32'h390;
    loadWord(encI(6'h23, 5'd0, 5'd5, 16'h038C), 32'h38C);
    loadWord(encI(6'h23, 5'd5, 5'd4, 16'hFFFC), 32'h38C);
    storeWord(encI(6'h2B, 5'd0, 5'd4, 16'h0388));
    chk(lastWdata == 32'h390, "R7 load data to rt", lastWdata, 32'h390);

    // R5 branch taken and not taken
    mem[224] = 9; mem[225] = 9;
    loadWord(encI(6'h23, 5'd0, 5'd1, 16'h0380), 32'h380);
    loadWord(encI(6'h23, 5'd0, 5'd2, 16'h0384), 32'h384);
    branchEq(encI(6'h04, 5'd1, 5'd2, 16'd3), 1'b1);
    mem[225] = 8;
    loadWord(encI(6'h23, 5'd0, 5'd2, 16'h0384), 32'h384);
    branchEq(encI(6'h04, 5'd1, 5'd2, 16'd3), 1'b0);

    // R6 jump target
    fetchDecode({6'h02, 26'h80});
    clr; pcWrite = 1; pcSrc = 2'b10; tick;
    pcModel = 32'h200;
    clr; #1;
    chk(memAddr == 32'h200, "R6 jump target", memAddr, 32'h200);

    // R2 IR holds without irWrite, R11 opcode field
    mem[pcModel[9:2]] = encI(6'h2B, 5'd0, 5'd0, 16'h0388);
    clr; memRead = 1; irWrite = 1; aluSrcB = 2'b01; pcWrite = 1; tick;
    pcModel += 4;
    chk(opcode == 6'h2B, "R11 opcode field", 32'(opcode), 32'h2B);
    chk(memAddr == pcModel, "R2 PC advanced by 4", memAddr, pcModel);
    mem[pcModel[9:2]] = encI(6'h23, 5'd0, 5'd0, 16'h0);
    clr; memRead = 1; #1;
    chk(memRe == 1'b1, "R10 read strobe", 32'(memRe), 1);
    tick;
    chk(opcode == 6'h2B, "R2 IR hold", 32'(opcode), 32'h2B);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule